// File: doc/BRIEF.md
# Tagged Stateless Custom Function Unit

This block is a programmable functional unit placed next to a processor register file. It holds a single resident function, made of one 4-input lookup table per result bit, together with the 11-bit tag that names that function. The 11-bit tag gives software a space of 2048 user-defined operations. When the processor issues a custom operation, it presents a tag and two 32-bit register operands. If the unit holds a complete function and the tag matches, the unit returns the 32-bit result combinationally in the same cycle. If not, it raises a fault in the same cycle and echoes the offending tag, so that a trap handler can load the right function and retry.

The unit keeps no data between operations. Only the function tables and their tag persist, so a context switch needs no save or restore. A new function arrives as a serial bitstream through a shift-enable, data and load-done interface. A small loader state machine decides when the resident function may be used.

The loader has three states. `LD_EMPTY` means no usable function is resident. `LD_SHIFT` means a bitstream is being shifted in. `LD_ARMED` means a complete function is resident. The transitions are as follows:
- EMPTY→SHIFT and ARMED→SHIFT happen on any shift enable.
- SHIFT→ARMED happens on load-done after exactly the full stream length.
- SHIFT→EMPTY happens on load-done after any other length.
- In every other case the state holds.

Top module: `xfn_unit`

## Requirements
- R1: When `issue_valid` is high, the unit is armed and `issue_id` (11 bits) equals the resident tag, `res_valid` is high and `fault` is low in that same cycle.
- R2: When `issue_valid` is high and the unit is not armed or the tag differs in any bit, `fault` is high, `fault_id` equals `issue_id`, `res_valid` is low and `res_data` is zero, all in that same cycle.
- R3: Result bit i is entry s of table i, where s = {op_b[(i+1)%32], op_b[i], op_a[(i+1)%32], op_a[i]} (op_a[i] is the LSB of s). The result is combinational in the issue cycle.
- R4: The result depends only on the current operands and the resident function. Earlier operations leave no trace.
- R5: Each cycle with `cfg_en` high shifts `cfg_din` in. The stream is 523 bits long and is ordered as follows: the 11-bit tag MSB first, then table 31 down to table 0, each table from entry 15 down to entry 0.
- R6: A `cfg_done` pulse while loading arms the unit from the next cycle only if exactly 523 bits were shifted. With fewer or more bits, the unit stays unarmed and every issue faults.
- R7: Any cycle with `cfg_en` high disarms the unit from the next cycle on. Issues during a load fault.
- R8: `cfg_done` is ignored when no load is in progress. It is also ignored in a cycle where `cfg_en` is high (that cycle only shifts).
- R9: After reset the unit is unarmed, so every issued operation faults.
- R10: With `issue_valid` low, `res_valid` and `fault` are low and `res_data` and `fault_id` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Shift enable for the configuration stream |
| cfg_din | input | 1 | Configuration stream bit |
| cfg_done | input | 1 | Load-done strobe |
| issue_valid | input | 1 | A custom operation is issued this cycle |
| issue_id | input | 11 | Function tag of the issued operation |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Second register operand |
| res_valid | output | 1 | Result is valid this cycle |
| res_data | output | 32 | Result, zero when not valid |
| fault | output | 1 | Tag miss or unarmed unit, one-cycle pulse per issue |
| fault_id | output | 11 | Tag that missed, zero when no fault |

## Verification
Results and faults are due in the issue cycle itself, with no register on the path. The bench drives each issue on the falling edge and compares all four outputs 1 ns later, before the next rising edge. Loader effects follow exactly one rising edge after the sampled `cfg_en` or `cfg_done`. The behavioural model therefore updates its armed flag, bit queue and decoded tables on each rising edge, and the following falling-edge comparison observes the new state. Direct checks of the XOR and rotated-AND functions confirm the bit pairing of R3 without going through the model.

// File: rtl/xfn_pkg.sv
package xfn_pkg;
    typedef enum logic [1:0] {
        LD_EMPTY = 2'd0,
        LD_SHIFT = 2'd1,
        LD_ARMED = 2'd2
    } ld_state_t;
endpackage

// File: rtl/xfn_lut4.sv
module xfn_lut4 #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] tbl,
    input  logic [K-1:0]      sel,
    output logic              y
);
    always_comb begin
        y = tbl[sel];
    end
endmodule

// File: rtl/xfn_array.sv
module xfn_array #(
    parameter int DATA_W = 32,
    parameter int TBL_W  = 16
) (
    input  logic [DATA_W*TBL_W-1:0] tables,
    input  logic [DATA_W-1:0]       a,
    input  logic [DATA_W-1:0]       b,
    output logic [DATA_W-1:0]       y
);
    localparam int K = $clog2(TBL_W);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam int NXT = (i + 1) % DATA_W;
        logic [K-1:0] sel;
        assign sel = {b[NXT], b[i], a[NXT], a[i]};
        xfn_lut4 #(.K(K)) u_lut (
            .tbl (tables[i*TBL_W +: TBL_W]),
            .sel (sel),
            .y   (y[i])
        );
    end
endmodule

// File: rtl/xfn_loader.sv
module xfn_loader
    import xfn_pkg::*;
#(
    parameter int ID_W  = 11,
    parameter int LUTS  = 32,
    parameter int TBL_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_en,
    input  logic                    cfg_din,
    input  logic                    cfg_done,
    output logic                    armed,
    output ld_state_t               state_o,
    output logic [ID_W-1:0]         loaded_id,
    output logic [LUTS*TBL_W-1:0]   tables
);
    localparam int CFG_LEN = ID_W + LUTS * TBL_W;
    localparam int CNT_W   = $clog2(CFG_LEN + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_LEN);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CFG_LEN + 1);

    ld_state_t            state, state_nx;
    logic [CNT_W-1:0]     cnt;
    logic [CFG_LEN-1:0]   shreg;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LD_EMPTY;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            LD_EMPTY: if (cfg_en) state_nx = LD_SHIFT;
            LD_SHIFT: begin
                if (!cfg_en && cfg_done)
                    state_nx = (cnt == CNT_FULL) ? LD_ARMED : LD_EMPTY;
            end
            LD_ARMED: if (cfg_en) state_nx = LD_SHIFT;
            default:  state_nx = LD_EMPTY;
        endcase
    end

    // bit counter, saturating one past the full length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cfg_en) begin
            if (state != LD_SHIFT)  cnt <= CNT_W'(1);
            else if (cnt != CNT_OVER) cnt <= cnt + CNT_W'(1);
        end
    end

    // configuration chain
    always_ff @(posedge clk) begin
        if (!rst_n)      shreg <= '0;
        else if (cfg_en) shreg <= {shreg[CFG_LEN-2:0], cfg_din};
    end

    // outputs
    always_comb begin
        armed     = (state == LD_ARMED);
        state_o   = state;
        loaded_id = shreg[CFG_LEN-1 -: ID_W];
        tables    = shreg[LUTS*TBL_W-1:0];
    end

    AST_ARM_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(cnt) == CNT_FULL);                         // R6
    AST_SHIFT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> !armed);                                               // R7
    AST_TABLES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(armed)) |-> $stable(shreg));                      // R4
    AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LD_ARMED && !cfg_en && cfg_done) |=> armed);            // R8
endmodule

// File: rtl/xfn_unit.sv
module xfn_unit
    import xfn_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic              cfg_done,
    input  logic              issue_valid,
    input  logic [ID_W-1:0]   issue_id,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              fault,
    output logic [ID_W-1:0]   fault_id
);
    localparam int LUT_K = 4;
    localparam int TBL_W = 1 << LUT_K;

    logic                      armed;
    ld_state_t                 ld_state;
    logic [ID_W-1:0]           loaded_id;
    logic [DATA_W*TBL_W-1:0]   tables;
    logic [DATA_W-1:0]         lut_y;
    logic                      hit;

    xfn_loader #(.ID_W(ID_W), .LUTS(DATA_W), .TBL_W(TBL_W)) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_din   (cfg_din),
        .cfg_done  (cfg_done),
        .armed     (armed),
        .state_o   (ld_state),
        .loaded_id (loaded_id),
        .tables    (tables)
    );

    xfn_array #(.DATA_W(DATA_W), .TBL_W(TBL_W)) u_array (
        .tables (tables),
        .a      (op_a),
        .b      (op_b),
        .y      (lut_y)
    );

    always_comb begin
        hit       = issue_valid && armed && (issue_id == loaded_id);
        res_valid = hit;
        res_data  = hit ? lut_y : '0;
        fault     = issue_valid && !hit;
        fault_id  = (issue_valid && !hit) ? issue_id : '0;
    end

    AST_NO_RESULT_WHILE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state == LD_SHIFT) |-> !res_valid);                           // R7
    AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && fault));                                           // R2
    AST_FAULT_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_id == issue_id && res_data == '0));              // R2
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (!res_valid && !fault && fault_id == '0));       // R10
endmodule

// File: tb/xfn_unit_tb_top.sv
module xfn_unit_tb_top;
    localparam int W   = 32;
    localparam int IDW = 11;
    localparam int CL  = IDW + W * 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           cfg_en = 1'b0, cfg_din = 1'b0, cfg_done = 1'b0;
    logic           issue_valid = 1'b0;
    logic [IDW-1:0] issue_id = '0;
    logic [W-1:0]   op_a = '0, op_b = '0;
    logic           res_valid, fault;
    logic [W-1:0]   res_data;
    logic [IDW-1:0] fault_id;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    xfn_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_done(cfg_done), .issue_valid(issue_valid), .issue_id(issue_id),
        .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_data(res_data),
        .fault(fault), .fault_id(fault_id)
    );

    // behavioural reference model
    bit             q[$];
    bit             m_loading = 1'b0;
    bit             m_armed   = 1'b0;
    logic [IDW-1:0] m_id = '0;
    logic [15:0]    m_tbl [W];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_loading = 1'b0;
            m_armed   = 1'b0;
            q.delete();
        end else if (cfg_en) begin
            if (!m_loading) begin
                q.delete();
                m_loading = 1'b1;
            end
            m_armed = 1'b0;
            q.push_back(cfg_din);
        end else if (cfg_done && m_loading) begin
            m_loading = 1'b0;
            if (q.size() == CL) begin
                m_armed = 1'b1;
                for (int j = 0; j < IDW; j++) m_id[IDW-1-j] = q[j];
                for (int k = 0; k < W; k++)
                    for (int e = 0; e < 16; e++)
                        m_tbl[W-1-k][15-e] = q[IDW + 16*k + e];
            end else begin
                m_armed = 1'b0;
            end
        end
    end

    function automatic logic [W-1:0] ref_result(logic [W-1:0] a, logic [W-1:0] b);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int n;
            logic [3:0] s;
            n = (i + 1) % W;
            s = {b[n], b[i], a[n], a[i]};
            r[i] = m_tbl[i][s];
        end
        return r;
    endfunction

    task automatic compare(string tag);
        logic           e_rv, e_f;
        logic [W-1:0]   e_d;
        logic [IDW-1:0] e_fid;
        e_rv = 1'b0; e_f = 1'b0; e_d = '0; e_fid = '0;
        if (issue_valid && m_armed && issue_id == m_id) begin
            e_rv = 1'b1;
            e_d  = ref_result(op_a, op_b);
        end else if (issue_valid) begin
            e_f   = 1'b1;
            e_fid = issue_id;
        end
        n_tests++;
        if (res_valid !== e_rv || res_data !== e_d || fault !== e_f || fault_id !== e_fid) begin
            n_fail++;
            $display("FAIL %s: rv=%b data=%h fault=%b fid=%h expected rv=%b data=%h fault=%b fid=%h",
                     tag, res_valid, res_data, fault, fault_id, e_rv, e_d, e_f, e_fid);
        end
    endtask

    task automatic cyc(string tag, logic en, logic din, logic done,
                       logic iv, logic [IDW-1:0] id, logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        cfg_en = en; cfg_din = din; cfg_done = done;
        issue_valid = iv; issue_id = id; op_a = a; op_b = b;
        #1;
        compare(tag);
    endtask

    task automatic direct(string tag, logic [W-1:0] exp_d);
        n_tests++;
        if (res_valid !== 1'b1 || res_data !== exp_d) begin
            n_fail++;
            $display("FAIL %s direct: rv=%b data=%h expected rv=1 data=%h",
                     tag, res_valid, res_data, exp_d);
        end
    endtask

    // shift n bits of stream (zero beyond its end) with issues in flight, then pulse done
    task automatic load(string tag, logic [CL-1:0] s, int n, logic [IDW-1:0] probe);
        for (int k = 0; k < n; k++)
            cyc(tag, 1'b1, (k < CL) ? s[CL-1-k] : 1'b0, 1'b0,
                (k % 7) == 0, probe, $urandom, $urandom);
        cyc(tag, 1'b0, 1'b0, 1'b1, 1'b1, probe, $urandom, $urandom);
    endtask

    function automatic logic [CL-1:0] build(logic [IDW-1:0] id, logic [15:0] t [W]);
        logic [CL-1:0] s;
        s[CL-1 -: IDW] = id;
        for (int j = 0; j < W; j++)
            s[CL-1-IDW-16*(W-1-j) -: 16] = t[j];
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0]   t [W];
        logic [CL-1:0] s;
        logic [W-1:0]  a, b;

        // R9: reset, unarmed, every issue faults
        cyc("R9", 0, 0, 0, 1, 11'h000, 32'h0, 32'h0);
        cyc("R9", 0, 0, 0, 1, 11'h2A5, 32'h1234, 32'h5678);
        @(negedge clk); rst_n = 1'b1;
        cyc("R9", 0, 0, 1, 1, 11'h000, 32'h0, 32'h0);
        cyc("R10", 0, 0, 0, 0, 11'h3FF, 32'hFFFF_FFFF, 32'h1);

        // R5 R6: function A = bitwise XOR, tag 0x2A5
        for (int j = 0; j < W; j++)
            for (int e = 0; e < 16; e++) t[j][e] = e[0] ^ e[2];
        s = build(11'h2A5, t);
        load("R7", s, CL, 11'h2A5);
        a = 32'hDEAD_BEEF; b = 32'h0F0F_1234;
        cyc("R1", 0, 0, 0, 1, 11'h2A5, a, b); direct("R3", a ^ b);
        a = 32'hFFFF_FFFF; b = 32'h0000_0000;
        cyc("R1", 0, 0, 0, 1, 11'h2A5, a, b); direct("R3", a ^ b);
        // R2: tag miss in MSB, LSB, all-zero
        cyc("R2", 0, 0, 0, 1, 11'h6A5, a, b);
        cyc("R2", 0, 0, 0, 1, 11'h2A4, a, b);
        cyc("R2", 0, 0, 0, 1, 11'h000, a, b);
        // R10: no issue
        cyc("R10", 0, 0, 0, 0, 11'h2A5, a, b);
        // R8: done without load is ignored, still armed
        cyc("R8", 0, 0, 1, 0, 11'h000, 32'h0, 32'h0);
        cyc("R8", 0, 0, 0, 1, 11'h2A5, 32'h1, 32'h3); direct("R8", 32'h2);
        // R4: back-to-back operations with unrelated operands
        for (int k = 0; k < 40; k++) begin
            a = $urandom; b = $urandom;
            cyc("R4", 0, 0, 0, 1, (k % 3 == 0) ? 11'h2A1 : 11'h2A5, a, b);
        end

        // function B = a[i+1] & b[i+1], tag 0x7FF
        for (int j = 0; j < W; j++)
            for (int e = 0; e < 16; e++) t[j][e] = e[1] & e[3];
        s = build(11'h7FF, t);
        load("R7", s, CL, 11'h7FF);
        a = 32'h8000_0001; b = 32'hC000_0003;
        cyc("R3", 0, 0, 0, 1, 11'h7FF, a, b);
        direct("R3", {a[0], a[W-1:1]} & {b[0], b[W-1:1]});
        a = 32'hA5A5_5A5A; b = 32'hFFFF_0000;
        cyc("R3", 0, 0, 0, 1, 11'h7FF, a, b);
        direct("R3", {a[0], a[W-1:1]} & {b[0], b[W-1:1]});
        cyc("R2", 0, 0, 0, 1, 11'h2A5, a, b);

        // R6: short and long streams leave the unit unarmed
        load("R6", s, CL - 1, 11'h7FF);
        cyc("R6", 0, 0, 0, 1, 11'h7FF, a, b);
        load("R6", s, CL + 1, 11'h7FF);
        cyc("R6", 0, 0, 0, 1, 11'h7FF, a, b);
        cyc("R6", 0, 0, 0, 1, 11'h000, a, b);

        // R8: done together with the last shift is ignored; R5 random tables
        for (int j = 0; j < W; j++) t[j] = 16'($urandom);
        s = build(11'h001, t);
        for (int k = 0; k < CL; k++)
            cyc("R8", 1, s[CL-1-k], (k == CL - 1), (k % 11) == 0, 11'h001, $urandom, $urandom);
        cyc("R8", 0, 0, 0, 1, 11'h001, 32'h5, 32'h9);
        cyc("R8", 0, 0, 1, 1, 11'h001, 32'h5, 32'h9);
        for (int k = 0; k < 100; k++)
            cyc("R5", 0, 0, 0, (k % 5) != 4, (k % 4 == 0) ? 11'h401 : 11'h001, $urandom, $urandom);

        // R7: a single shift disarms
        cyc("R7", 1, 0, 0, 1, 11'h001, 32'h1, 32'h1);
        cyc("R7", 0, 0, 0, 1, 11'h001, 32'h1, 32'h1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule